// File: doc/BRIEF.md
# Windowed Command and Interrupt Controller

This block is the host-facing control point of a network adapter. The host writes 16-bit command words to one port. Each word is split into a 5-bit opcode and an 11-bit argument, and the block decodes it into strobes. Those strobes select a register window, acknowledge interrupt sources, load the interrupt mask and the receive filter, and switch the receiver, the transmitter and statistics collection on or off.

Seven event sources pulse `evt_i`, and the block latches each pulse into a status bit. A status bit whose mask bit is set drives the single interrupt line. The 16-bit status word is read combinationally. It carries the latched sources, a command-in-progress flag, and the active window number.

A global-reset command clears all control state and then holds the busy flag for a fixed number of cycles. Commands written while the busy flag is set are dropped.

Top module: `win_cmd_ctrl`

## Requirements
- R1: A command word carries its opcode in bits 15..11 and its argument in bits 10..0. A command is taken on a clock edge where `cmd_we_i` is 1. Argument bits that a command does not use have no effect.
- R2: Opcode 1 sets the active window to argument bits 2..0. Status bits 15..13 report the active window.
- R3: Status bits 7..1 are, from bit 1 upward: adapter failure, TX complete, TX available, RX complete, RX early, interrupt requested, update statistics. A 1 on `evt_i[k]` sets status bit k on the next edge. Bits 11..8 read 0.
- R4: Opcode 13 is the acknowledge. Each set bit k (0..7) in its argument clears status bit k. If an event pulse for the same bit arrives in the same cycle, the event wins.
- R5: Opcode 12 sets status bit 6. Opcode 14 loads the interrupt mask from argument bits 7..1.
- R6: `irq_o` is 1 while any status bit in 7..1 is set together with its mask bit. Status bit 0 reads 1 whenever `irq_o` is 1. It then stays 1 until it is acknowledged with argument bit 0 at a time when `irq_o` is 0.
- R7: Opcode 16 loads `rx_filter_o` from argument bits 3..0. Bit 0 is individual, bit 1 multicast, bit 2 broadcast, bit 3 promiscuous.
- R8: Opcodes 4 and 3 enable and disable the receiver. Opcodes 9 and 10 enable and disable the transmitter. Opcodes 21 and 22 enable and disable statistics.
- R9: Opcode 0 clears the window, the status bits, the mask, the filter and all enables. Status bit 12 then reads 1 for exactly 16 cycles, and commands written during that time are ignored.
- R10: Opcodes that are not listed above leave all state unchanged.
- R11: While `rst_ni` is 0, status reads 0x0000 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_data_i | input | 16 | Command word |
| evt_i | input | 7 | Event pulses for status bits 7..1 |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt line |
| rx_filter_o | output | 4 | Receive filter flags |
| rx_en_o | output | 1 | Receiver enabled |
| tx_en_o | output | 1 | Transmitter enabled |
| stats_en_o | output | 1 | Statistics enabled |

## Verification
The assertions check the following on every cycle:
- an event pulse sets its status bit;
- an acknowledge clears its bits unless an event arrives for the same bit;
- an asserted interrupt leaves the latch bit set;
- the busy counter stays within range and starts after a global reset;
- the window cannot move while the block is busy;
- the enables drop after a global reset.

Only the bench scenarios can show the exact 16-cycle busy length, the bit positions of each opcode's effect, that unknown opcodes and unused argument bits have no effect, and the full status word seen from the host side.

// File: rtl/win_cmd_pkg.sv
package win_cmd_pkg;
  localparam int CMD_W = 16;
  localparam int OP_W  = 5;
  localparam int ARG_W = CMD_W - OP_W;
  localparam int WIN_W = 3;
  localparam int NSRC  = 8;

  typedef enum logic [OP_W-1:0] {
    OP_GLB_RST  = 5'd0,
    OP_WIN_SEL  = 5'd1,
    OP_RX_OFF   = 5'd3,
    OP_RX_ON    = 5'd4,
    OP_TX_ON    = 5'd9,
    OP_TX_OFF   = 5'd10,
    OP_REQ_INT  = 5'd12,
    OP_ACK      = 5'd13,
    OP_MASK     = 5'd14,
    OP_FILT     = 5'd16,
    OP_STAT_ON  = 5'd21,
    OP_STAT_OFF = 5'd22
  } op_e;

  typedef struct packed {
    logic glb_rst;
    logic win_sel;
    logic rx_off;
    logic rx_on;
    logic tx_on;
    logic tx_off;
    logic req_int;
    logic ack;
    logic mask_ld;
    logic filt_ld;
    logic stat_on;
    logic stat_off;
    logic [ARG_W-1:0] arg;
  } cmd_dec_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import win_cmd_pkg::*;
(
  input  logic             we_i,
  input  logic             busy_i,
  input  logic [CMD_W-1:0] data_i,
  output cmd_dec_t         dec_o
);
  logic   take;
  op_e    op;

  assign take = we_i & ~busy_i;
  assign op   = op_e'(data_i[CMD_W-1:ARG_W]);

  always_comb begin
    dec_o     = '0;
    dec_o.arg = data_i[ARG_W-1:0];
    if (take) begin
      unique case (op)
        OP_GLB_RST:  dec_o.glb_rst  = 1'b1;
        OP_WIN_SEL:  dec_o.win_sel  = 1'b1;
        OP_RX_OFF:   dec_o.rx_off   = 1'b1;
        OP_RX_ON:    dec_o.rx_on    = 1'b1;
        OP_TX_ON:    dec_o.tx_on    = 1'b1;
        OP_TX_OFF:   dec_o.tx_off   = 1'b1;
        OP_REQ_INT:  dec_o.req_int  = 1'b1;
        OP_ACK:      dec_o.ack      = 1'b1;
        OP_MASK:     dec_o.mask_ld  = 1'b1;
        OP_FILT:     dec_o.filt_ld  = 1'b1;
        OP_STAT_ON:  dec_o.stat_on  = 1'b1;
        OP_STAT_OFF: dec_o.stat_off = 1'b1;
        default: ;  // unknown opcode: no strobe
      endcase
    end
  end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int CYCLES = 16,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);  // R9
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CYCLES));  // R9
endmodule

// File: rtl/int_ctrl.sv
module int_ctrl
  import win_cmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            req_i,
  input  logic            ack_i,
  input  logic            mask_ld_i,
  input  logic [NSRC-1:0] arg_i,
  input  logic [NSRC-1:1] evt_i,
  output logic [NSRC-1:0] stat_o,
  output logic            irq_o
);
  logic [NSRC-1:1] stat_q, mask_q, set_v, clr_v;
  logic            latch_q;

  for (genvar k = 1; k < NSRC; k++) begin : g_src
    // bit 6 is also set by the request command
    assign set_v[k] = evt_i[k] | ((k == 6) ? req_i : 1'b0);
    assign clr_v[k] = ack_i & arg_i[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        stat_q[k] <= 1'b0;
      else if (clr_i)     stat_q[k] <= 1'b0;
      else if (set_v[k])  stat_q[k] <= 1'b1;
      else if (clr_v[k])  stat_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mask_q <= '0;
    else if (clr_i)      mask_q <= '0;
    else if (mask_ld_i)  mask_q <= arg_i[NSRC-1:1];
  end

  assign irq_o = |(stat_q & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    latch_q <= 1'b0;
    else if (clr_i) latch_q <= 1'b0;
    else            latch_q <= irq_o | (latch_q & ~(ack_i & arg_i[0]));
  end

  assign stat_o = {stat_q, latch_q | irq_o};

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && |evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));  // R3
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !clr_i) |=> ((stat_q & $past(arg_i[NSRC-1:1] & ~set_v)) == '0));  // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> latch_q);  // R6
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import win_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_dec_t         dec_i,
  output logic [WIN_W-1:0] win_o,
  output logic [3:0]       filt_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             stat_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_o     <= '0;
      filt_o    <= '0;
      rx_en_o   <= 1'b0;
      tx_en_o   <= 1'b0;
      stat_en_o <= 1'b0;
    end else if (dec_i.glb_rst) begin
      win_o     <= '0;
      filt_o    <= '0;
      rx_en_o   <= 1'b0;
      tx_en_o   <= 1'b0;
      stat_en_o <= 1'b0;
    end else begin
      if (dec_i.win_sel)  win_o     <= dec_i.arg[WIN_W-1:0];
      if (dec_i.filt_ld)  filt_o    <= dec_i.arg[3:0];
      if (dec_i.rx_on)    rx_en_o   <= 1'b1;
      if (dec_i.rx_off)   rx_en_o   <= 1'b0;
      if (dec_i.tx_on)    tx_en_o   <= 1'b1;
      if (dec_i.tx_off)   tx_en_o   <= 1'b0;
      if (dec_i.stat_on)  stat_en_o <= 1'b1;
      if (dec_i.stat_off) stat_en_o <= 1'b0;
    end
  end

  AST_RST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i.glb_rst |=> (!rx_en_o && !tx_en_o && !stat_en_o));  // R8
endmodule

// File: rtl/win_cmd_ctrl.sv
module win_cmd_ctrl
  import win_cmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  input  logic [NSRC-1:1]  evt_i,
  output logic [CMD_W-1:0] status_o,
  output logic             irq_o,
  output logic [3:0]       rx_filter_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             stats_en_o
);
  cmd_dec_t         dec;
  logic             busy;
  logic [WIN_W-1:0] win;
  logic [NSRC-1:0]  stat;

  cmd_decode u_dec (
    .we_i   (cmd_we_i),
    .busy_i (busy),
    .data_i (cmd_data_i),
    .dec_o  (dec)
  );

  busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dec.glb_rst),
    .busy_o  (busy)
  );

  int_ctrl u_int (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (dec.glb_rst),
    .req_i     (dec.req_int),
    .ack_i     (dec.ack),
    .mask_ld_i (dec.mask_ld),
    .arg_i     (dec.arg[NSRC-1:0]),
    .evt_i     (evt_i),
    .stat_o    (stat),
    .irq_o     (irq_o)
  );

  cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_i     (dec),
    .win_o     (win),
    .filt_o    (rx_filter_o),
    .rx_en_o   (rx_en_o),
    .tx_en_o   (tx_en_o),
    .stat_en_o (stats_en_o)
  );

  assign status_o = {win, busy, 4'b0000, stat};

  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_we_i) |=> $stable(status_o[15:13]));  // R9
  AST_IRQ_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o[0]);  // R6
endmodule

// File: tb/tb_win_cmd_ctrl.sv
module tb_win_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  typedef struct packed {
    logic [15:0] cmd;
    logic [15:0] stat;
    logic        irq;
    logic [6:0]  cfg;  // {stats, tx, rx, filter[3:0]}
  } vec_t;

  // walked from reset state
  localparam vec_t TBL [NVEC] = '{
    '{16'h0805, 16'hA000, 1'b0, 7'h00},  // R2 window 5
    '{16'h2000, 16'hA000, 1'b0, 7'h10},  // R8 rx on
    '{16'h4800, 16'hA000, 1'b0, 7'h30},  // R8 tx on
    '{16'hA800, 16'hA000, 1'b0, 7'h70},  // R8 stats on
    '{16'h8005, 16'hA000, 1'b0, 7'h75},  // R7 filter
    '{16'h6000, 16'hA040, 1'b0, 7'h75},  // R5 request
    '{16'h7040, 16'hA041, 1'b1, 7'h75},  // R5 R6 mask
    '{16'h6840, 16'hA001, 1'b0, 7'h75},  // R4 ack bit6, latch stays
    '{16'h6801, 16'hA000, 1'b0, 7'h75},  // R6 ack latch
    '{16'h1800, 16'hA000, 1'b0, 7'h65},  // R8 rx off
    '{16'h5000, 16'hA000, 1'b0, 7'h45},  // R8 tx off
    '{16'hB000, 16'hA000, 1'b0, 7'h05},  // R8 stats off
    '{16'hFFFF, 16'hA000, 1'b0, 7'h05},  // R10 opcode 31
    '{16'h1007, 16'hA000, 1'b0, 7'h05},  // R10 opcode 2
    '{16'h0FFA, 16'h4000, 1'b0, 7'h05}   // R1 high arg bits ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] data = '0;
  logic [7:1]  evt = '0;
  logic [15:0] status;
  logic        irq;
  logic [3:0]  filt;
  logic        rx_en, tx_en, st_en;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_cmd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_data_i(data),
    .evt_i(evt), .status_o(status), .irq_o(irq), .rx_filter_o(filt),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .stats_en_o(st_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [15:0] c, input logic [7:1] e);
    @(negedge clk);
    we = w; data = c; evt = e;
    @(negedge clk);
    we = 1'b0; data = '0; evt = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int n;
    #(CLK_PERIOD * 3);
    chk("R11 status", status, 16'h0000);
    chk("R11 outs", {irq, st_en, tx_en, rx_en, filt}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, TBL[i].cmd, '0);
      chk($sformatf("vec%0d status", i), status, TBL[i].stat);
      chk($sformatf("vec%0d irq", i), irq, TBL[i].irq);
      chk($sformatf("vec%0d cfg", i), {st_en, tx_en, rx_en, filt}, TBL[i].cfg);
    end

    // R3 events latch, masked off (mask = bit6 only)
    step(1'b0, '0, 7'b0001010);  // bits 4,2
    chk("R3 evt set", status, 16'h4014);
    chk("R6 masked irq", irq, 1'b0);
    step(1'b1, 16'h7010, '0);
    chk("R6 irq on", irq, 1'b1);
    chk("R6 latch bit", status, 16'h4015);
    // R4 ack bits 4,2 with simultaneous event on bit 2
    step(1'b1, 16'h6814, 7'b0000010);
    chk("R4 event wins", status, 16'h4005);
    chk("R4 irq off", irq, 1'b0);
    step(1'b1, 16'h6805, '0);
    chk("R4 ack all", status, 16'h4000);

    // R9 global reset and busy window
    step(1'b1, 16'hA800, '0);
    step(1'b1, 16'h7080, 7'b1000000);
    chk("R9 pre", irq, 1'b1);
    step(1'b1, 16'h0000, '0);
    chk("R9 status", status, 16'h1000);
    chk("R9 cfg", {irq, st_en, tx_en, rx_en, filt}, 32'h0);
    n = 1;
    step(1'b1, 16'h0803, '0);
    n += 2;
    chk("R9 cmd ignored", status, 16'h1000);
    for (int g = 0; g < 40; g++) begin
      @(negedge clk);
      if (!status[12]) break;
      n++;
    end
    chk("R9 busy length", n, 16);
    chk("R9 after busy", status, 16'h0000);
    step(1'b1, 16'h0803, '0);
    chk("R2 window after busy", status, 16'h6000);

    // R11 async reset mid-run
    step(1'b0, '0, 7'b1111111);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 async", status, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule